// File: doc/BRIEF.md
# Serial Write-Word Receiver with Ready Flow Control

This block is the receiving end of a one-way serial write link. The link has a clock line, an active-low select line and a data line. All three are asynchronous to the block's own system clock, so they are sampled and edge-detected inside the block. When select goes low, a transaction opens. The first byte names the target device and the transfer direction. If that byte selects this device for a write, every following group of four bytes forms a 32-bit word. Each word appears on a parallel bus together with a valid flag.

A consumer takes a word by raising an accept input. Until it does, the block holds the word steady and pulls its ready output low. A master uses this to pace itself: after each word it waits for ready to return high, then clocks in the next four bytes. If the first byte names a different device or a read, the block ignores everything else in that selection. When select returns high, the transaction closes. Any unfinished word or byte is then dropped.

The control is a four-state machine:
- `ST_IDLE`: no selection is open.
- `ST_ADDR`: collecting the device/direction byte.
- `ST_DATA`: collecting data bytes.
- `ST_SKIP`: the selection is ignored.

Its transitions are:
- IDLE→ADDR on select falling.
- ADDR→DATA when the first byte matches.
- ADDR→SKIP when the first byte does not match.
- ADDR, DATA or SKIP→IDLE on select rising.

Top module: `spi_word_rx`

## Requirements
- R1: After reset, `word_valid` is 0 and `ready` is 1.
- R2: A falling edge on `spi_cs_n` restarts the bit and byte counts, and the next complete byte is taken as the device/direction byte.
- R3: The device/direction byte holds the 7-bit device address in bits 7:1 and the direction in bit 0 (0 = write). Only the value 0x80 (address 1000000b, write) is accepted. Any other value makes the block ignore every later byte until `spi_cs_n` goes high, and no word is produced.
- R4: `spi_mosi` is sampled on rising `spi_sclk` edges, most significant bit first. A byte is committed only on the falling `spi_sclk` edge that follows its eighth rising edge.
- R5: Four committed data bytes form one word. The first byte lands in `word_data[31:24]` and the fourth in `word_data[7:0]`.
- R6: While `word_valid` is 1 and `word_accept` is 0, `word_valid` stays 1 and `word_data` stays unchanged. A cycle with both high clears `word_valid` at the next clock edge.
- R7: `ready` is 0 exactly while a word is pending (`word_valid` = 1), and 1 otherwise.
- R8: When `spi_cs_n` rises before a word is complete, the bytes and bits gathered so far are discarded. They never appear in any later word.
- R9: Within one selection, words follow each other without a new device/direction byte. Each group of four data bytes yields the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| word_accept | input | 1 | Consumer takes the pending word |
| word_data | output | 32 | Assembled word |
| word_valid | output | 1 | A word is pending on `word_data` |
| ready | output | 1 | High when the block can take another word |

## Verification
The checker assumes a well-behaved master and consumer. The master clocks no further data while `ready` is low, and it never moves select in the same system cycle as a serial clock edge. The consumer never raises accept in the same cycle that a new word completes. The stimulus keeps within these limits in four ways. It holds each serial clock phase for several system clocks. It leaves idle cycles around every select edge. It waits for `ready` before each new word. It raises accept only after the serial clock has gone quiet.

// File: rtl/spi_word_rx_pkg.sv
package spi_word_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } rx_state_e;

endpackage

// File: rtl/spi_rx_sync.sv
// Brings the three serial lines into the system clock domain and flags their edges.
module spi_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_active,
    output logic mosi_s
);

    logic [STAGES-1:0] sclk_chain;
    logic [STAGES-1:0] cs_chain;
    logic [STAGES-1:0] mosi_chain;
    logic              sclk_prev;
    logic              cs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_chain <= '0;
            cs_chain   <= '1;
            mosi_chain <= '0;
            sclk_prev  <= 1'b0;
            cs_prev    <= 1'b1;
        end else begin
            sclk_chain <= {sclk_chain[STAGES-2:0], sclk_in};
            cs_chain   <= {cs_chain[STAGES-2:0], cs_n_in};
            mosi_chain <= {mosi_chain[STAGES-2:0], mosi_in};
            sclk_prev  <= sclk_chain[STAGES-1];
            cs_prev    <= cs_chain[STAGES-1];
        end
    end

    always_comb begin
        sclk_rise = sclk_chain[STAGES-1] & ~sclk_prev;
        sclk_fall = ~sclk_chain[STAGES-1] & sclk_prev;
        cs_fall   = ~cs_chain[STAGES-1] & cs_prev;
        cs_rise   = cs_chain[STAGES-1] & ~cs_prev;
        cs_active = ~cs_chain[STAGES-1];
        mosi_s    = mosi_chain[STAGES-1];
    end

endmodule

// File: rtl/spi_rx_shifter.sv
// Collects bits MSB first on sample strobes and commits a byte on the close strobe after the last bit.
module spi_rx_shifter #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 sample,
    input  logic                 close,
    input  logic                 bit_in,
    output logic                 byte_done,
    output logic [BYTE_BITS-1:0] byte_val
);

    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
            end else if (sample && bit_cnt < FULL) begin
                shreg   <= {shreg[BYTE_BITS-2:0], bit_in};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (close && bit_cnt == FULL) begin
                byte_done <= 1'b1;
                byte_val  <= shreg;
                bit_cnt   <= '0;
            end
        end
    end

endmodule

// File: rtl/spi_rx_word.sv
// Packs committed bytes into words and holds each word until it is accepted.
module spi_rx_word #(
    parameter int BYTE_BITS  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic                            byte_take,
    input  logic [BYTE_BITS-1:0]            byte_val,
    input  logic                            accept,
    output logic [WORD_BYTES*BYTE_BITS-1:0] word_data,
    output logic                            word_valid
);

    localparam int W     = WORD_BYTES * BYTE_BITS;
    localparam int ACC_W = W - BYTE_BITS;
    localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BYTES - 1);

    logic [IDX_W-1:0] idx;
    logic [ACC_W-1:0] accum;
    logic [ACC_W-1:0] accum_next;

    generate
        if (WORD_BYTES > 2) begin : g_deep
            assign accum_next = {accum[ACC_W-BYTE_BITS-1:0], byte_val};
        end else begin : g_shallow
            assign accum_next = byte_val;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx        <= '0;
            accum      <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            if (word_valid && accept) begin
                word_valid <= 1'b0;
            end
            if (flush) begin
                idx <= '0;
            end else if (byte_take) begin
                if (idx == LAST) begin
                    word_data  <= {accum, byte_val};
                    word_valid <= 1'b1;
                    idx        <= '0;
                end else begin
                    accum <= accum_next;
                    idx   <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_word_rx.sv
// Serial write-word receiver: selection control FSM over the sync, shifter and word stages.
module spi_word_rx
    import spi_word_rx_pkg::*;
#(
    parameter int                   SYNC_STAGES = 2,
    parameter int                   BYTE_BITS   = 8,
    parameter int                   WORD_BYTES  = 4,
    parameter logic [BYTE_BITS-2:0] DEV_ADDR    = 7'h40
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            spi_sclk,
    input  logic                            spi_cs_n,
    input  logic                            spi_mosi,
    input  logic                            word_accept,
    output logic [WORD_BYTES*BYTE_BITS-1:0] word_data,
    output logic                            word_valid,
    output logic                            ready
);

    localparam logic [BYTE_BITS-1:0] WRITE_KEY = {DEV_ADDR, 1'b0};

    rx_state_e            state;
    rx_state_e            state_nx;
    logic                 sclk_rise;
    logic                 sclk_fall;
    logic                 cs_fall;
    logic                 cs_rise;
    logic                 cs_active;
    logic                 mosi_s;
    logic                 byte_done;
    logic [BYTE_BITS-1:0] byte_val;
    logic                 data_take;
    logic                 edge_clear;

    assign edge_clear = cs_fall | cs_rise;

    spi_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    spi_rx_shifter #(.BYTE_BITS(BYTE_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (edge_clear),
        .sample    (sclk_rise & cs_active),
        .close     (sclk_fall & cs_active),
        .bit_in    (mosi_s),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    spi_rx_word #(.BYTE_BITS(BYTE_BITS), .WORD_BYTES(WORD_BYTES)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (edge_clear),
        .byte_take  (data_take),
        .byte_val   (byte_val),
        .accept     (word_accept),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cs_fall) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (cs_rise) begin
                    state_nx = ST_IDLE;
                end else if (byte_done) begin
                    state_nx = (byte_val == WRITE_KEY) ? ST_DATA : ST_SKIP;
                end
            end
            ST_DATA: if (cs_rise) state_nx = ST_IDLE;
            ST_SKIP: if (cs_rise) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        data_take = byte_done && (state == ST_DATA) && !cs_rise;
        ready     = !word_valid;
    end

endmodule

// File: rtl/spi_word_rx_chk.sv
module spi_word_rx_chk
    import spi_word_rx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_data,
    input  logic         word_valid,
    input  logic         word_accept,
    input  logic         ready,
    input  rx_state_e    state,
    input  logic         cs_rise
);

    initial assert (!(W < 1));

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !word_accept |=> word_valid && $stable(word_data)); // R6
    AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_accept |=> !word_valid); // R6
    AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !ready); // R7
    AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ready); // R7
    AST_WORD_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> $past(state) == ST_DATA); // R3
    AST_SKIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SKIP && !cs_rise |=> state == ST_SKIP); // R3

endmodule

bind spi_word_rx spi_word_rx_chk #(.W(WORD_BYTES*BYTE_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_data   (word_data),
    .word_valid  (word_valid),
    .word_accept (word_accept),
    .ready       (ready),
    .state       (state),
    .cs_rise     (cs_rise)
);

// File: tb/spi_word_rx_test.sv
module spi_word_rx_test;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        accept = 1'b0;
    logic [31:0] wdata;
    logic        wvalid;
    logic        rdy;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    spi_word_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (sclk),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .word_accept (accept),
        .word_data   (wdata),
        .word_valid  (wvalid),
        .ready       (rdy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            idle(HALF);
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int k = 3; k >= 0; k--) send_byte(w[k*8 +: 8]);
        idle(HALF);
    endtask

    task automatic cs_begin();
        idle(4);
        cs_n = 1'b0;
        idle(4);
    endtask

    task automatic cs_end();
        idle(4);
        cs_n = 1'b1;
        idle(8);
    endtask

    task automatic wait_valid();
        for (int t = 0; t < 32 && !wvalid; t++) idle(1);
    endtask

    task automatic take();
        accept = 1'b1;
        idle(1);
        accept = 1'b0;
        check(!wvalid, "R6 cleared after accept", {31'd0, wvalid}, 32'd0);
        check(rdy, "R7 ready after accept", {31'd0, rdy}, 32'd1);
    endtask

    function automatic logic [31:0] pat(input int i);
        logic [7:0] a;
        a = 8'(i);
        return {a ^ 8'hC3, ~a, a + 8'd17, 8'(a * 8'd7)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        idle(3);
        check(!wvalid, "R1 reset valid", {31'd0, wvalid}, 32'd0);
        check(rdy, "R1 reset ready", {31'd0, rdy}, 32'd1);
        rst_n = 1'b1;
        idle(3);

        // R3 / R5: sweep every first-byte value
        for (int a = 0; a < 256; a++) begin
            cs_begin();
            send_byte(8'(a));
            send_word(pat(a));
            cs_end();
            if (a == 8'h80) begin
                wait_valid();
                check(wvalid, "R3 accepted key", {31'd0, wvalid}, 32'd1);
                check(wdata == pat(a), "R5 word order", wdata, pat(a));
                check(!rdy, "R7 busy while pending", {31'd0, rdy}, 32'd0);
                take();
            end else begin
                check(!wvalid, "R3 rejected first byte", {24'd0, 8'(a)}, 32'h80);
            end
        end

        // R9: several words in one selection, paced by ready
        cs_begin();
        send_byte(8'h80);
        for (int j = 0; j < 12; j++) begin
            w = pat(j * 37 + 5) ^ (32'h1 << j);
            send_word(w);
            wait_valid();
            check(wvalid && wdata == w, "R9 back-to-back word", wdata, w);
            take();
        end
        cs_end();

        // R6: held while not accepted
        cs_begin();
        send_byte(8'h80);
        send_word(32'hA5_3C_0F_81);
        wait_valid();
        w = wdata;
        idle(40);
        check(wvalid && wdata == w, "R6 word held", wdata, w);
        check(!rdy, "R7 busy while held", {31'd0, rdy}, 32'd0);
        take();
        cs_end();

        // R4: no commit before the falling edge of the eighth clock
        cs_begin();
        send_byte(8'h80);
        send_byte(8'h12);
        send_byte(8'h34);
        send_byte(8'h56);
        send_bits(8'h78, 7);
        mosi = 1'b0;
        idle(HALF);
        sclk = 1'b1;
        idle(20);
        check(!wvalid, "R4 no commit at 8th rise", {31'd0, wvalid}, 32'd0);
        sclk = 1'b0;
        idle(HALF);
        wait_valid();
        check(wvalid && wdata == 32'h12345678, "R4 commit on 8th fall", wdata, 32'h12345678);
        take();
        cs_end();

        // R8: partial word dropped at select rise
        cs_begin();
        send_byte(8'h80);
        send_byte(8'hDE);
        send_byte(8'hAD);
        cs_end();
        idle(20);
        check(!wvalid, "R8 partial word dropped", {31'd0, wvalid}, 32'd0);

        // R8 / R2: partial bytes do not leak into the next selection
        cs_begin();
        send_byte(8'h80);
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'h33);
        send_bits(8'hFF, 5);
        cs_end();
        check(!wvalid, "R8 partial byte dropped", {31'd0, wvalid}, 32'd0);
        cs_begin();
        send_byte(8'h80);
        send_word(32'h0102_0408);
        cs_end();
        wait_valid();
        check(wvalid && wdata == 32'h01020408, "R2 counters restart", wdata, 32'h01020408);
        take();

        // R2: partial first byte of a selection is not carried over
        cs_begin();
        send_bits(8'hFF, 3);
        cs_end();
        cs_begin();
        send_byte(8'h80);
        send_word(32'hCAFE_0042);
        cs_end();
        wait_valid();
        check(wvalid && wdata == 32'hCAFE0042, "R2 address byte after restart", wdata, 32'hCAFE0042);
        take();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule